// File: doc/BRIEF.md
# Ordered Store Queue with Typed Fences

This block sits between a simple in-order core and a single-ported memory interface. It applies total-store-order rules. Stores from the core go into a small queue and leave for memory strictly in the order they arrived. A load whose address has no queued store may go to memory ahead of those older stores. A load whose address has queued stores takes its data from the youngest of them, byte by byte, and does not touch memory at all.

Ordering is controlled by one fence request that carries two 4-bit sets, one for the operations before the fence and one for those after it. The bits are I, O, R and W. A fence whose "before" set names writes holds back the operations in its "after" set until every store that was queued ahead of it has been committed. A fence whose "before" set names reads holds them back until the outstanding load has returned. The usual full, store-only and load-only fences are particular settings of the two sets.

The core side uses a valid/ready request channel and a one-cycle response strobe. The memory side uses a valid/ready request channel with one read in flight. Read data comes back on a strobe some cycles later.

Top module: `tso_store_buffer`

## Requirements
- R1: Stores (`req_op`=0) are written to memory exactly once each, with their own address, data and byte mask, and in the order they were accepted.
- R2: While `mem_valid` is high and `mem_ready` is low, the memory request (`mem_we`, `mem_addr`, `mem_wdata`, `mem_mask`) stays valid and unchanged in the next cycle.
- R3: A load (`req_op`=1) to an address with no queued store reads memory before older queued stores. Only a store that is already being offered and not yet taken stays ahead of it.
- R4: At most one load is in flight. A second load is refused while an earlier load has not yet responded, and no new read is issued while a read is outstanding.
- R5: When the queued stores to the load address together cover all bytes, each byte comes from the youngest covering store. `rsp_valid` rises in the cycle after acceptance, with no memory access.
- R6: When queued stores match the load address but do not cover every byte, no read is issued until all of them have been committed, and new stores are refused while that load waits. The value returned is the memory word after those writes.
- R7: With DEPTH stores queued, a store request sees `req_ready` low. It goes high again the cycle after a commit frees an entry.
- R8: A fence (`req_op`=2) whose `req_pred` has W (bit 0) or O (bit 2) set holds back, while any store queued ahead of it is uncommitted, every later request of a kind named in `req_succ`: stores for bit 0/2, loads for bit 1/3. The value 4'hF in both sets is the full fence.
- R9: A fence whose `req_pred` has R (bit 1) or I (bit 3) set holds back the kinds named in `req_succ` until the load outstanding at fence time has responded.
- R10: A fence whose `req_pred` has neither W nor O set does not wait for the queue to drain. A store that follows it is accepted at once even when the queue is not empty.
- R11: Synchronous `rst` discards all queued stores and fence state. None of the discarded stores reaches memory afterwards.
- R12: `idle` is high exactly when no store is queued and no fence is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Core request accepted when high with valid |
| req_op | input | 2 | 0 store, 1 load, 2 fence, 3 ignored |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_mask | input | DATA_W/8 | Store byte enables |
| req_pred | input | 4 | Fence "before" set {I,O,R,W} = bits 3..0 |
| req_succ | input | 4 | Fence "after" set {I,O,R,W} = bits 3..0 |
| rsp_valid | output | 1 | Load data strobe |
| rsp_data | output | DATA_W | Load data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request taken |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write data |
| mem_mask | output | DATA_W/8 | Write byte enables |
| mem_rvalid | input | 1 | Read data strobe |
| mem_rdata | input | DATA_W | Read data |
| idle | output | 1 | No queued store and no waiting fence |

## Verification
The bench aims at a load that meets two partial stores to the same word. A design that forwards per store rather than per byte would return a half-stale word. It also covers a load that meets only part of a word. A design that forwarded such a load anyway, or let it read memory early, would return the old bytes. The bypass case checks that the read goes out after exactly one commit: a design that drained first would show three commits, and one that dropped the offered store would break the handshake. The fence cases set a drain-type fence against a read-type fence on the same non-empty queue. A design that confused the two sets would stall the wrong request or release it too early. A reset in the middle of a fence must leave nothing to commit afterwards.

// File: rtl/tso_store_buffer.sv
`timescale 1ns/1ps
module tso_store_buffer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  input  logic [3:0]        req_pred,
  input  logic [3:0]        req_succ,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W/8-1:0] mem_mask,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              idle
);
  localparam int NB = DATA_W / 8;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int SW = 1 + NB + DATA_W;

  logic [ADDR_W-1:0] q_addr [DEPTH];
  logic [DATA_W-1:0] q_data [DEPTH];
  logic [NB-1:0]     q_mask [DEPTH];
  logic [PW-1:0]     head, tail;
  logic [CW-1:0]     count;

  logic              ld_pend, ld_out, fwd_v, st_lock;
  logic [ADDR_W-1:0] ld_addr;
  logic [DATA_W-1:0] fwd_q;
  logic [CW-1:0]     fen_cnt;
  logic              fen_r, fen_succ_w, fen_succ_r;

  function automatic logic [SW-1:0] scan(input logic [ADDR_W-1:0] a);
    logic any;
    logic [NB-1:0] cov;
    logic [DATA_W-1:0] d;
    logic [PW-1:0] idx;
    any = 1'b0; cov = '0; d = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PW'(k);
      if (CW'(k) < count && q_addr[idx] == a) begin
        any = 1'b1;
        for (int b = 0; b < NB; b++)
          if (q_mask[idx][b]) begin
            cov[b] = 1'b1;
            d[8*b +: 8] = q_data[idx][8*b +: 8];
          end
      end
    end
    return {any, cov, d};
  endfunction

  logic [SW-1:0] req_scan, ld_scan;
  assign req_scan = scan(req_addr);
  assign ld_scan  = scan(ld_addr);

  logic req_full, ld_match, fpend, ld_busy;
  assign req_full = &req_scan[DATA_W +: NB];
  assign ld_match = ld_scan[SW-1];
  assign fpend    = (fen_cnt != '0) || fen_r;
  assign ld_busy  = ld_pend || ld_out || fwd_v;

  logic st_ok, ld_ok;
  assign st_ok = (count < CW'(DEPTH)) && !ld_pend && !(fpend && fen_succ_w);
  assign ld_ok = !ld_busy && !(fpend && fen_succ_r);

  always_comb begin
    case (req_op)
      2'd0:    req_ready = st_ok;
      2'd1:    req_ready = ld_ok;
      2'd2:    req_ready = !fpend;
      default: req_ready = 1'b1;
    endcase
  end

  logic acc, push, ld_acc, fn_acc;
  assign acc    = req_valid && req_ready;
  assign push   = acc && req_op == 2'd0;
  assign ld_acc = acc && req_op == 2'd1;
  assign fn_acc = acc && req_op == 2'd2;

  logic sel_ld, pop, rd_go;
  assign sel_ld    = ld_pend && !ld_match && !st_lock;
  assign mem_valid = sel_ld || (count != '0);
  assign mem_we    = !sel_ld;
  assign mem_addr  = sel_ld ? ld_addr : q_addr[head];
  assign mem_wdata = q_data[head];
  assign mem_mask  = sel_ld ? '1 : q_mask[head];
  assign pop       = mem_valid && mem_ready && mem_we;
  assign rd_go     = mem_valid && mem_ready && !mem_we;

  assign rsp_valid = fwd_v || (ld_out && mem_rvalid);
  assign rsp_data  = fwd_v ? fwd_q : mem_rdata;
  assign idle      = (count == '0) && !fpend;

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[tail] <= req_addr;
      q_data[tail] <= req_wdata;
      q_mask[tail] <= req_mask;
    end
    fwd_q <= req_scan[DATA_W-1:0];
    if (ld_acc) ld_addr <= req_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0; tail <= '0; count <= '0;
      ld_pend <= 1'b0; ld_out <= 1'b0; fwd_v <= 1'b0; st_lock <= 1'b0;
      fen_cnt <= '0; fen_r <= 1'b0; fen_succ_w <= 1'b0; fen_succ_r <= 1'b0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      count   <= count + CW'(push) - CW'(pop);
      st_lock <= mem_valid && !mem_ready && mem_we;
      fwd_v   <= ld_acc && req_full;
      if (ld_acc && !req_full) ld_pend <= 1'b1;
      else if (rd_go)          ld_pend <= 1'b0;
      if (rd_go)           ld_out <= 1'b1;
      else if (mem_rvalid) ld_out <= 1'b0;
      if (fn_acc) begin
        fen_cnt    <= (req_pred[0] || req_pred[2]) ? count - CW'(pop) : '0;
        fen_r      <= (req_pred[1] || req_pred[3]) && ld_busy;
        fen_succ_w <= req_succ[0] || req_succ[2];
        fen_succ_r <= req_succ[1] || req_succ[3];
      end else begin
        if (pop && fen_cnt != '0) fen_cnt <= fen_cnt - 1'b1;
        if (fen_r && !ld_busy)    fen_r <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tso_store_buffer_chk.sv
`timescale 1ns/1ps
module tso_store_buffer_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W/8-1:0] mem_mask,
  input logic              idle,
  input logic [$clog2(DEPTH):0] count,
  input logic [$clog2(DEPTH):0] fen_cnt,
  input logic              fen_succ_w,
  input logic              ld_pend,
  input logic              ld_out,
  input logic              ld_match
);
  // R2
  hold_request_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_wdata) && $stable(mem_mask)));
  // R4
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    ld_out |-> !(mem_valid && !mem_we));
  // R6
  partial_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_pend && ld_match) |-> !(mem_valid && !mem_we));
  // R7
  full_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (count == ($clog2(DEPTH)+1)'(DEPTH) && req_valid && req_op == 2'd0) |-> !req_ready);
  // R8
  fence_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (fen_cnt != '0 && fen_succ_w) |=> (count <= $past(count)));
  // R11
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (idle && !mem_valid));
endmodule

bind tso_store_buffer tso_store_buffer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_mask(mem_mask), .idle(idle), .count(count),
  .fen_cnt(fen_cnt), .fen_succ_w(fen_succ_w), .ld_pend(ld_pend), .ld_out(ld_out),
  .ld_match(ld_match));

// File: tb/tso_store_buffer_tb.sv
`timescale 1ns/1ps
module tso_store_buffer_tb;
  localparam int CLK_P = 10;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam int DEPTH = 4;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_ready;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0;
  logic [NB-1:0] req_mask = 0;
  logic [3:0] req_pred = 0, req_succ = 0;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;
  logic mem_valid, mem_ready, mem_we, mem_rvalid, idle;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [NB-1:0] mem_mask;

  logic mr_man = 1, rnd_mode = 0, rnd_bit = 1;
  assign mem_ready = rnd_mode ? rnd_bit : mr_man;

  always #(CLK_P/2) clk = ~clk;

  tso_store_buffer #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask), .req_pred(req_pred),
    .req_succ(req_succ), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_mask(mem_mask), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .idle(idle));

  int errs = 0, checks = 0;
  int wr_cnt = 0, rd_mark = 0, rlat = 1, rcnt = 0;
  logic rvq = 0;
  logic [DW-1:0] rdq = 0;
  logic [DW-1:0] mem [16];
  logic [DW-1:0] arch [16];
  logic [AW-1:0] eq_a [$];
  logic [DW-1:0] eq_d [$];
  logic [NB-1:0] eq_m [$];
  logic [DW-1:0] ld_exp;
  assign mem_rvalid = rvq;
  assign mem_rdata  = rdq;

  function automatic logic [DW-1:0] base(int i);
    return 32'hA5000000 ^ (i * 32'h00010203);
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] o, logic [DW-1:0] n, logic [NB-1:0] m);
    logic [DW-1:0] r = o;
    for (int b = 0; b < NB; b++) if (m[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    rvq <= 1'b0;
    if (rst) begin
      rcnt <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= base(i);
    end else begin
      if (rcnt == 1) begin rvq <= 1'b1; end
      if (rcnt > 0) rcnt <= rcnt - 1;
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          mem[mem_addr] <= merge(mem[mem_addr], mem_wdata, mem_mask);
          if (eq_a.size() == 0) chk(0, "R1 unexpected write", {28'd0, mem_addr}, 0);
          else begin
            chk(mem_addr == eq_a[0] && mem_wdata == eq_d[0] && mem_mask == eq_m[0],
                "R1 commit order", mem_wdata, eq_d[0]);
            void'(eq_a.pop_front()); void'(eq_d.pop_front()); void'(eq_m.pop_front());
          end
          wr_cnt++;
        end else begin
          rdq <= mem[mem_addr];
          rcnt <= rlat;
          rd_mark = wr_cnt;
        end
      end
    end
  end

  initial begin : rnd_gen
    int s = $urandom(7);
    s = 0;
    forever begin
      @(negedge clk);
      rnd_bit = ($urandom % 4) != 0;
    end
  end

  task automatic send(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                      logic [NB-1:0] m, logic [3:0] p, logic [3:0] s);
    @(negedge clk);
    req_op = op; req_addr = a; req_wdata = d; req_mask = m; req_pred = p; req_succ = s;
    req_valid = 1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (op == 2'd0) begin
      arch[a] = merge(arch[a], d, m);
      eq_a.push_back(a); eq_d.push_back(d); eq_m.push_back(m);
    end
    if (op == 2'd1) ld_exp = arch[a];
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic store(logic [AW-1:0] a, logic [DW-1:0] d, logic [NB-1:0] m);
    send(2'd0, a, d, m, 4'h0, 4'h0);
  endtask
  task automatic load(logic [AW-1:0] a);
    send(2'd1, a, 0, 0, 4'h0, 4'h0);
  endtask
  task automatic fence(logic [3:0] p, logic [3:0] s);
    send(2'd2, 0, 0, 0, p, s);
  endtask

  task automatic wait_rsp(string tag, int maxc, output int took);
    took = -1;
    for (int k = 0; k < maxc; k++) begin
      @(negedge clk);
      if (rsp_valid) begin took = k; break; end
    end
    chk(took >= 0 && rsp_data == ld_exp, tag, rsp_data, ld_exp);
  endtask

  task automatic probe(logic [1:0] op, output logic r);
    @(negedge clk);
    req_op = op;
    #1 r = req_ready;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (idle && eq_a.size() == 0) break;
    end
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < 16; i++) arch[i] = base(i);
    eq_a.delete(); eq_d.delete(); eq_m.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    logic r, seen;
    int took, w0;
    do_reset();

    // R11 R12 reset state
    probe(2'd0, r);
    chk(idle == 1 && mem_valid == 0 && r == 1, "R11 R12 reset state", {idle, mem_valid, r}, 3'b101);

    // R5 forwarding, youngest per byte, no memory access
    mr_man = 0;
    store(3, 32'h11223344, 4'hF);
    store(3, 32'hAABBCCDD, 4'h3);
    chk(idle == 0, "R12 busy with queued stores", idle, 0);
    load(3);
    wait_rsp("R5 youngest forward", 4, took);
    chk(took == 0, "R5 forward latency", took, 0);
    store(4, 32'h01020304, 4'h3);
    store(4, 32'h50607080, 4'hC);
    load(4);
    wait_rsp("R5 merged forward", 4, took);
    chk(took == 0 && wr_cnt == 0, "R5 no memory access", wr_cnt, 0);

    // R7 full queue stalls stores, frees after one commit
    probe(2'd0, r);
    chk(r == 0, "R7 full stall", r, 0);
    mr_man = 1;
    probe(2'd0, r);
    chk(r == 1 && wr_cnt == 1, "R7 ready after commit", {r, wr_cnt[7:0]}, 9'h101);
    wait_idle();

    // R3 load bypasses older stores
    mr_man = 0;
    store(1, 32'hDEAD0001, 4'hF);
    store(1, 32'hDEAD0002, 4'hF);
    store(2, 32'hDEAD0003, 4'hF);
    load(5);
    w0 = wr_cnt;
    mr_man = 1;
    wait_rsp("R3 bypass data", 20, took);
    chk(rd_mark - w0 == 1, "R3 read before later stores", rd_mark - w0, 1);
    wait_idle();

    // R6 partial coverage waits for drain
    mr_man = 0;
    store(6, 32'h000000EE, 4'h1);
    load(6);
    seen = 0;
    repeat (6) begin @(negedge clk); if (rsp_valid) seen = 1; end
    chk(seen == 0, "R6 no early response", seen, 0);
    probe(2'd0, r);
    chk(r == 0, "R6 store refused while load waits", r, 0);
    w0 = wr_cnt;
    mr_man = 1;
    wait_rsp("R6 data after drain", 20, took);
    chk(rd_mark - w0 == 1, "R6 read after write", rd_mark - w0, 1);
    wait_idle();

    // R4 one load in flight
    mr_man = 0;
    load(8);
    probe(2'd1, r);
    chk(r == 0, "R4 second load refused", r, 0);
    mr_man = 1;
    wait_rsp("R4 load data", 20, took);
    probe(2'd1, r);
    chk(r == 1, "R4 load ready after response", r, 1);

    // R8 full fence waits for drain
    mr_man = 0;
    store(9, 32'h90909090, 4'hF);
    store(10, 32'hA0A0A0A0, 4'hF);
    fence(4'hF, 4'hF);
    probe(2'd0, r);
    chk(r == 0, "R8 store held by full fence", r, 0);
    probe(2'd1, r);
    chk(r == 0, "R8 load held by full fence", r, 0);
    w0 = wr_cnt;
    mr_man = 1;
    for (int k = 0; k < 10; k++) begin
      probe(2'd0, r);
      if (r) break;
    end
    chk(r == 1 && wr_cnt - w0 == 2, "R8 released after both commits", wr_cnt - w0, 2);
    wait_idle();

    // R10 read-only predecessor does not drain; R8 write predecessor does
    mr_man = 0;
    store(14, 32'hE1E2E3E4, 4'hF);
    fence(4'h2, 4'h1);
    probe(2'd0, r);
    chk(r == 1, "R10 store accepted past fence", r, 1);
    fence(4'h1, 4'h1);
    probe(2'd0, r);
    chk(r == 0, "R8 store fence holds store", r, 0);
    probe(2'd1, r);
    chk(r == 1, "R8 store fence lets load go", r, 1);
    mr_man = 1;
    wait_idle();

    // R9 read predecessor waits for outstanding load
    rlat = 8;
    load(13);
    fence(4'h2, 4'h1);
    probe(2'd0, r);
    chk(r == 0, "R9 store held by load fence", r, 0);
    wait_rsp("R9 load data", 30, took);
    for (int k = 0; k < 5; k++) begin
      probe(2'd0, r);
      if (r) break;
    end
    chk(r == 1, "R9 released after load return", r, 1);
    rlat = 1;

    // R11 reset discards queued stores and fences
    mr_man = 0;
    store(7, 32'h77777777, 4'hF);
    store(11, 32'hBBBBBBBB, 4'hF);
    fence(4'hF, 4'hF);
    w0 = wr_cnt;
    do_reset();
    probe(2'd0, r);
    chk(idle == 1 && r == 1 && mem_valid == 0, "R11 cleared by reset", {idle, r, mem_valid}, 3'b110);
    mr_man = 1;
    repeat (6) @(negedge clk);
    chk(wr_cnt == w0, "R11 nothing committed after reset", wr_cnt - w0, 0);

    // R1 sweep with back-pressure and mixed requests
    rnd_mode = 1;
    for (int n = 0; n < 800; n++) begin
      int pick = $urandom % 20;
      logic [AW-1:0] a = AW'($urandom % 8);
      rlat = 1 + ($urandom % 3);
      if (pick < 9) store(a, $urandom, NB'($urandom));
      else if (pick < 16) begin
        load(a);
        wait_rsp("R1 sweep load value", 300, took);
      end else fence(4'($urandom), 4'($urandom));
    end
    wait_idle();
    repeat (4) @(negedge clk);
    for (int i = 0; i < 16; i++) chk(mem[i] == arch[i], "R1 final memory", mem[i], arch[i]);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule